// File: doc/BRIEF.md
# Full-Speed USB Frame Timer with Frame-List Pointer

This block paces a host controller's schedule. It counts a 12 MHz tick, given as a clock-enable pulse on the core clock, and emits a start-of-frame strobe once per frame. Frame length is set by a 7-bit trim value added to a fixed base count. Each strobe advances an 11-bit frame number. The low ten bits of that number, together with a 4 KB-aligned table base, form the memory address of the current frame-list entry.

Software writes two registers through a simple write port. One is the table base, of which only the upper bits are kept. The other is the frame-trim register, with one reserved bit. A trim write goes into a shadow copy. The running frame keeps its length, and the new value is taken only when the frame ends. A run input gates the whole timer. A synchronous controller reset returns the block to its defaults.

Top module: `usb_frame_timer`

## Requirements
- R1: While running with the tick high every cycle, consecutive SOF pulses are exactly BASE_LEN + trim cycles apart, where trim is the 7-bit frame-trim value in force for that frame. BASE_LEN is 11936 by default.
- R2: After reset, the frame-trim register reads 0x40 (trim 64). The base register reads 0, the frame number is 0, and the entry address is 0.
- R3: The trim register readback (`trim_rd`) returns the last written `wr_data[6:0]` in bits 6:0. Bit 7 always reads 0, whatever value was written to it.
- R4: A trim write does not change the length of the frame in progress. The written value governs the frame that begins at the next SOF.
- R5: `sof` is a one-cycle pulse. It is asserted only in a cycle where `run` was already high in the previous cycle, `run` and `tick` are high, `ctrl_rst` is low, and the frame timer has reached its terminal count.
- R6: While `run` is low, the frame number and the timer hold and no SOF is produced. In the cycle `run` rises, a fresh frame is loaded using the current shadow trim, and the next SOF comes BASE_LEN + trim ticks later.
- R7: The frame number is 11 bits wide. It increments by one at each SOF, changes at no other time, and wraps from 2047 to 0.
- R8: `entry_addr` equals {base[31:12], frame_num[9:0], 2'b00}.
- R9: A base write (`wr_sel` = 0) stores `wr_data[31:12]`. `base_rd` returns those bits with bits 11:0 reading 0.
- R10: `ctrl_rst` high at a clock edge restores every R2 default and suppresses SOF in that cycle. It takes precedence over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_rst | input | 1 | Synchronous controller reset |
| run | input | 1 | Run enable for the frame timer |
| tick | input | 1 | 12 MHz counting enable, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = table base, 1 = frame trim |
| wr_data | input | 32 | Write data |
| base_rd | output | 32 | Table base readback, low 12 bits zero |
| trim_rd | output | 8 | Frame-trim readback, bit 7 zero |
| sof | output | 1 | Start-of-frame strobe |
| frame_num | output | 11 | Current frame number |
| entry_addr | output | 32 | Address of the current frame-list entry |

## Verification
The bench builds the block with BASE_LEN set to 20 and keeps the other parameters at their defaults. A frame then lasts 20 to 147 cycles rather than about 12000. This makes it possible to run more than two thousand frames and observe the frame number wrapping from 2047 to 0. It also allows many trim changes and run toggles to be checked at every frame boundary within the cycle budget. The trim field width, the 4 KB table alignment and the 1024-entry index are the production values, so address formation and the reserved-bit behaviour are checked as built.

// File: rtl/usbft_pkg.sv
package usbft_pkg;
  typedef enum logic {
    SEL_BASE = 1'b0,
    SEL_TRIM = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/usbft_regs.sv
module usbft_regs #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 12,
  parameter int TRIM_W     = 7,
  parameter int TRIM_RST   = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctrl_rst,
  input  logic                       wr_en,
  input  usbft_pkg::wr_sel_e         wr_sel,
  input  logic [ADDR_W-1:0]          wr_data,
  output logic [ADDR_W-ALIGN_BITS-1:0] base_hi_o,
  output logic [TRIM_W-1:0]          trim_o
);
  import usbft_pkg::*;
  localparam int HI_W = ADDR_W - ALIGN_BITS;

  logic [HI_W-1:0]   base_q, base_d;
  logic [TRIM_W-1:0] trim_q, trim_d;

  always_comb begin
    base_d = base_q;
    trim_d = trim_q;
    if (ctrl_rst) begin
      base_d = '0;
      trim_d = TRIM_W'(TRIM_RST);
    end else if (wr_en) begin
      if (wr_sel == SEL_BASE) base_d = wr_data[ADDR_W-1:ALIGN_BITS];
      else                    trim_d = wr_data[TRIM_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      trim_q <= TRIM_W'(TRIM_RST);
    end else begin
      base_q <= base_d;
      trim_q <= trim_d;
    end
  end

  assign base_hi_o = base_q;
  assign trim_o    = trim_q;

  assert_trim_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_TRIM && !ctrl_rst) |=> trim_q == $past(wr_data[TRIM_W-1:0]));

  assert_base_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_BASE && !ctrl_rst) |=> base_q == $past(wr_data[ADDR_W-1:ALIGN_BITS]));

  assert_ctrl_rst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst |=> (trim_q == TRIM_W'(TRIM_RST) && base_q == '0));
endmodule

// File: rtl/usbft_timer.sv
module usbft_timer #(
  parameter int BASE_LEN = 11936,
  parameter int TRIM_W   = 7,
  parameter int TRIM_RST = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_rst,
  input  logic              run,
  input  logic              tick,
  input  logic [TRIM_W-1:0] trim_i,
  output logic              sof_o
);
  localparam int MAX_LEN = BASE_LEN + (1 << TRIM_W) - 1;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, reload;
  logic             run_q, run_d;
  logic             rise, sof;

  assign reload = CNT_W'(BASE_LEN - 1) + CNT_W'(trim_i);
  assign rise   = run && !run_q;
  assign sof    = run && run_q && tick && (cnt_q == '0) && !ctrl_rst;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run;
    if (ctrl_rst) begin
      cnt_d = CNT_W'(BASE_LEN + TRIM_RST - 1);
      run_d = 1'b0;
    end else if (rise) begin
      cnt_d = reload;
    end else if (run && tick) begin
      if (cnt_q == '0) cnt_d = reload;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(BASE_LEN + TRIM_RST - 1);
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign sof_o = sof;

  assert_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> cnt_q == CNT_W'(BASE_LEN - 1) + CNT_W'($past(trim_i)));

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_LEN - 1));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !sof);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ctrl_rst) |=> $stable(cnt_q));
endmodule

// File: rtl/usbft_frame_ctr.sv
module usbft_frame_ctr #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 12,
  parameter int FRAME_W    = 11,
  parameter int INDEX_W    = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ctrl_rst,
  input  logic                          sof_i,
  input  logic [ADDR_W-ALIGN_BITS-1:0]  base_hi_i,
  output logic [FRAME_W-1:0]            frame_o,
  output logic [ADDR_W-1:0]             addr_o
);
  localparam int ENTRY_LSB = ALIGN_BITS - INDEX_W;

  logic [FRAME_W-1:0] frame_q, frame_d;

  always_comb begin
    frame_d = frame_q;
    if (ctrl_rst)   frame_d = '0;
    else if (sof_i) frame_d = frame_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else        frame_q <= frame_d;
  end

  assign frame_o = frame_q;

  generate
    if (ENTRY_LSB > 0) begin : g_dword
      assign addr_o = {base_hi_i, frame_q[INDEX_W-1:0], {ENTRY_LSB{1'b0}}};
    end else begin : g_packed
      assign addr_o = {base_hi_i, frame_q[INDEX_W-1:0]};
    end
  endgenerate

  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_i && !ctrl_rst) |=> frame_q == $past(frame_q) + 1'b1);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof_i && !ctrl_rst) |=> $stable(frame_q));
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 12,
  parameter int FRAME_W    = 11,
  parameter int INDEX_W    = 10,
  parameter int TRIM_W     = 7,
  parameter int TRIM_RST   = 64,
  parameter int BASE_LEN   = 11936
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_rst,
  input  logic              run,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] base_rd,
  output logic [TRIM_W:0]   trim_rd,
  output logic              sof,
  output logic [FRAME_W-1:0] frame_num,
  output logic [ADDR_W-1:0] entry_addr
);
  import usbft_pkg::*;
  localparam int HI_W = ADDR_W - ALIGN_BITS;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [HI_W-1:0]   base_hi;
  logic [TRIM_W-1:0] trim;
  logic              sof_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  usbft_regs #(
    .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .TRIM_W(TRIM_W), .TRIM_RST(TRIM_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .ctrl_rst(ctrl_rst), .wr_en(wr_en),
    .wr_sel(wr_sel_e'(wr_sel)), .wr_data(wr_data),
    .base_hi_o(base_hi), .trim_o(trim)
  );

  usbft_timer #(
    .BASE_LEN(BASE_LEN), .TRIM_W(TRIM_W), .TRIM_RST(TRIM_RST)
  ) u_timer (
    .clk(clk), .rst_n(rst_int_n), .ctrl_rst(ctrl_rst), .run(run), .tick(tick),
    .trim_i(trim), .sof_o(sof_w)
  );

  usbft_frame_ctr #(
    .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .FRAME_W(FRAME_W), .INDEX_W(INDEX_W)
  ) u_frame (
    .clk(clk), .rst_n(rst_int_n), .ctrl_rst(ctrl_rst), .sof_i(sof_w),
    .base_hi_i(base_hi), .frame_o(frame_num), .addr_o(entry_addr)
  );

  assign base_rd = {base_hi, {ALIGN_BITS{1'b0}}};
  assign trim_rd = {1'b0, trim};
  assign sof     = sof_w;

  assert_sof_gated_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    sof |-> (run && tick && !ctrl_rst && $past(run)));
endmodule

// File: tb/tb_usb_frame_timer.sv
module tb_usb_frame_timer;
  localparam int BL = 20;

  logic        clk = 1'b0;
  logic        rst_n, ctrl_rst, run, tick, wr_en, wr_sel;
  logic [31:0] wr_data, base_rd, entry_addr;
  logic [7:0]  trim_rd;
  logic        sof;
  logic [10:0] frame_num;

  usb_frame_timer #(.BASE_LEN(BL)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_rst(ctrl_rst), .run(run), .tick(tick),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .base_rd(base_rd),
    .trim_rd(trim_rd), .sof(sof), .frame_num(frame_num), .entry_addr(entry_addr)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int          m_cnt;
  logic [6:0]  m_trim;
  logic [10:0] m_frame;
  logic [19:0] m_base;
  logic        m_runq;
  int          gap, last_gap;
  logic        seen_2047, seen_wrap;

  function automatic int flen(input logic [6:0] t);
    return BL + int'(t);
  endfunction

  function automatic logic [31:0] faddr(input logic [19:0] b, input logic [10:0] f);
    return {b, f[9:0], 2'b00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = flen(7'd64) - 1; m_trim = 7'd64; m_frame = '0; m_base = '0; m_runq = 1'b0;
  endtask

  task automatic step(input logic i_run, input logic i_tick, input logic i_ctrl,
                      input logic i_wr, input logic i_sel, input logic [31:0] i_data);
    logic exp_sof;
    logic [6:0] old_trim;
    @(negedge clk);
    run = i_run; tick = i_tick; ctrl_rst = i_ctrl; wr_en = i_wr; wr_sel = i_sel; wr_data = i_data;
    #1;
    exp_sof = i_run && m_runq && i_tick && (m_cnt == 0) && !i_ctrl;
    chk("R5 sof", {31'd0, sof}, {31'd0, exp_sof});
    if (i_run && !m_runq) gap = 0;
    else begin
      gap++;
      if (sof) begin last_gap = gap; gap = 0; end
    end
    @(posedge clk);
    old_trim = m_trim;
    if (i_ctrl) model_reset();
    else begin
      if (i_run && !m_runq) m_cnt = flen(old_trim) - 1;
      else if (i_run && i_tick) begin
        if (m_cnt == 0) begin m_cnt = flen(old_trim) - 1; m_frame++; end
        else m_cnt--;
      end
      m_runq = i_run;
      if (i_wr) begin
        if (i_sel) m_trim = i_data[6:0];
        else       m_base = i_data[31:12];
      end
    end
    #1;
    chk("R7 frame", {21'd0, frame_num}, {21'd0, m_frame});
    chk("R8 addr", entry_addr, faddr(m_base, m_frame));
    chk("R9 base_rd", base_rd, {m_base, 12'h000});
    chk("R3 trim_rd", {24'd0, trim_rd}, {25'd0, m_trim});
    if (frame_num == 11'd2047) seen_2047 = 1'b1;
    if (seen_2047 && frame_num == 11'd0) seen_wrap = 1'b1;
  endtask

  task automatic idle(input int n, input logic r);
    for (int i = 0; i < n; i++) step(r, 1'b1, 1'b0, 1'b0, 1'b0, 32'd0);
  endtask

  task automatic wtrim(input logic r, input logic [6:0] t);
    step(r, 1'b1, 1'b0, 1'b1, 1'b1, {25'd0, t});
  endtask

  task automatic wait_sof(input logic r);
    int k = 0;
    do begin idle(1, r); k++; end while (!(sof === 1'b0 && last_gap > 0 && gap == 0) && k < 400);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0042);
    run = 0; tick = 0; ctrl_rst = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
    gap = 0; last_gap = 0; seen_2047 = 0; seen_wrap = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);

    // R2 reset state
    chk("R2 trim_rd default", {24'd0, trim_rd}, 32'h40);
    chk("R2 base default", base_rd, 32'd0);
    chk("R2 frame default", {21'd0, frame_num}, 32'd0);
    chk("R2 addr default", entry_addr, 32'd0);

    // R9 / R8: base masking, R3: reserved bit
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    chk("R9 base masked", base_rd, 32'hFFFF_F000);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h1234_5ABC);
    chk("R8 addr frame0", entry_addr, 32'h1234_5000);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_00FF);
    chk("R3 bit7 reads zero", {24'd0, trim_rd}, 32'h7F);

    // R6: run rise starts a frame of shadow length (127)
    idle(1, 1'b1);
    do idle(1, 1'b1); while (!(gap == 0 && last_gap != 0));
    chk("R6 first frame after rise", last_gap, flen(7'd127));
    wait_sof(1'b1);
    chk("R1 length trim127", last_gap, flen(7'd127));
    chk("R7 frame after two sofs", {21'd0, frame_num}, 32'd2);

    // R1 trim 0 and default 64
    wtrim(1'b1, 7'd0);
    wait_sof(1'b1); wait_sof(1'b1);
    chk("R1 length trim0", last_gap, flen(7'd0));
    wtrim(1'b1, 7'd64);
    wait_sof(1'b1); wait_sof(1'b1);
    chk("R1 length trim64", last_gap, flen(7'd64));

    // R4: mid-frame write does not alter the current frame
    wtrim(1'b1, 7'd10);
    wait_sof(1'b1); wait_sof(1'b1);
    idle(5, 1'b1);
    wtrim(1'b1, 7'd50);
    wait_sof(1'b1);
    chk("R4 current frame unchanged", last_gap, flen(7'd10));
    wait_sof(1'b1);
    chk("R4 next frame uses new trim", last_gap, flen(7'd50));

    // R6: run low holds everything
    idle(3, 1'b1);
    begin
      logic [10:0] f0;
      f0 = frame_num;
      idle(300, 1'b0);
      chk("R6 frame held while stopped", {21'd0, frame_num}, {21'd0, f0});
    end

    // R10: ctrl_rst beats a same-cycle write
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0005);
    chk("R10 trim after ctrl_rst", {24'd0, trim_rd}, 32'h40);
    chk("R10 frame after ctrl_rst", {21'd0, frame_num}, 32'd0);
    chk("R10 base after ctrl_rst", base_rd, 32'd0);

    // R7: wrap with shortest frames
    wtrim(1'b0, 7'd0);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'hABCD_E000);
    idle(2049 * BL + 40, 1'b1);
    chk("R7 saw 2047 then wrap to 0", {31'd0, seen_wrap}, 32'd1);

    // constrained random
    begin
      logic r = 1'b1;
      for (int i = 0; i < 40000; i++) begin
        logic tk, cr, we, ws;
        logic [31:0] d;
        if ($urandom % 150 == 0) r = ~r;
        tk = ($urandom % 4) != 0;
        cr = ($urandom % 3000) == 0;
        we = ($urandom % 200) == 0;
        ws = $urandom % 2;
        d  = $urandom;
        step(r, tk, cr, we, ws, d);
      end
    end

    done = 1;
    finish_run();
  end
endmodule